// File: doc/BRIEF.md
# Configurable Logic Cell Storage Element

This block is the storage stage of one cell in a programmable logic fabric. It receives two logic terms from the array in front of it and one value from its own I/O pin. Static configuration inputs set how the cell works. The output can follow the data directly, come from an edge-triggered register, or come from a level-sensitive latch. The register can behave as a D, toggle, JK or set/clear flip-flop: a small XOR-based stage in front of the register combines the terms with the present stored value. The stored value can be inverted before it leaves the cell. An uninverted copy is always available as internal feedback, so the cell can still feed other logic while its pin is used for something else.

The clock lines and set/reset lines are sampled signals inside one system clock domain, so no derived clocks exist. The cell picks one of the clock lines and detects its rising or falling transition, as configured. That transition is the register's capture event. In latch mode the same line, at its active level, opens the latch. The cell also picks one set/reset line pair, or none. When set and reset are active at a capture they override the data, and reset wins over set. In input-register mode the cell ignores the logic terms and stores the pin value, and it releases the pin for input.

Top module: `pld_cell`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises with all inputs at 0, `fb_out` and `cell_out` are 0.
- R2: With `cfg_mode`=00 (pass-through; 11 behaves the same), `fb_out` equals the data source in the same cycle. The data source is `term_a`, or `pin_in` in input-register mode. Set/reset and clock lines have no effect.
- R3: With `cfg_mode`=01 (registered) and `cfg_ff`=00 (D), the stored value takes `term_a` only on a capture event of the line chosen by `cfg_clk_sel`. Changes on other lines leave it unchanged. `fb_out` shows the new value one cycle after the line's sampled transition.
- R4: `cfg_edge_neg`=0 captures on a 0→1 sample of the chosen line. `cfg_edge_neg`=1 captures on a 1→0 sample. For latches it makes the low level the open level.
- R5: With `cfg_ff`=01 (toggle), a capture stores Q xor `term_a`.
- R6: With `cfg_ff`=10 (JK, `term_a`=J, `term_b`=K), a capture stores 1 for J only, 0 for K only, the inverse of Q for both, and Q for neither.
- R7: With `cfg_ff`=11 (set/clear, `term_a`=S, `term_b`=R), a capture stores 1 for S only, 0 for R only, and Q for both or neither.
- R8: `cfg_sr_sel` values 0..2 pick the pair `set_lines[i]`/`rst_lines[i]`, and 3 picks none. At a capture, an active reset stores 0 and otherwise an active set stores 1, whatever the data. Unselected lines have no effect.
- R9: With `cfg_mode`=10 (latch), while the chosen line is at its open level `fb_out` equals the D-type next value in the same cycle and it is stored. While the line is closed, the stored value holds.
- R10: With `cfg_in_reg`=1, the stored and pass-through value comes from `pin_in` with D behaviour. `term_a`/`term_b` and `cfg_ff` are ignored, and `pin_oe` is 0 (1 otherwise).
- R11: `cell_out` equals `fb_out` inverted when `cfg_invert`=1, and equal to it otherwise.
- R12: `fb_out` never carries the inversion, so the internal feedback keeps the true stored value in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 00 pass-through, 01 registered, 10 latch, 11 pass-through |
| cfg_ff | input | 2 | Emulated flip-flop: 00 D, 01 toggle, 10 JK, 11 set/clear |
| cfg_clk_sel | input | 2 | Chosen clock line |
| cfg_edge_neg | input | 1 | 1: falling capture / low-open latch |
| cfg_sr_sel | input | 2 | Chosen set/reset pair, 3 = none |
| cfg_invert | input | 1 | Output polarity inversion |
| cfg_in_reg | input | 1 | Input-register mode: data from pin |
| term_a | input | 1 | Logic term: D, T, J or S |
| term_b | input | 1 | Logic term: K or R |
| pin_in | input | 1 | Value received on the cell's pin |
| clk_lines | input | 4 | Sampled clock lines |
| set_lines | input | 3 | Set lines |
| rst_lines | input | 3 | Reset lines |
| cell_out | output | 1 | Polarity-adjusted output to pin |
| fb_out | output | 1 | Uninverted internal feedback |
| pin_oe | output | 1 | Pin drive enable, low in input-register mode |

## Verification
A wrong stored value is never masked. In registered mode it shows on `fb_out` and `cell_out` in the cycle after the capture event, and it stays there until the next capture. That makes a wrong toggle or JK decision visible at once, and it then spreads into every later toggle result. A wrong edge detector or line selection shows as a capture on the wrong sample or a missed one, which the reference model compares one cycle later. Latch and pass-through faults appear in the same cycle as the stimulus.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_REG   = 2'b01,
        MODE_LATCH = 2'b10,
        MODE_PASS2 = 2'b11
    } cell_mode_e;

    typedef enum logic [1:0] {
        FF_D  = 2'b00,
        FF_T  = 2'b01,
        FF_JK = 2'b10,
        FF_SR = 2'b11
    } ff_kind_e;

    typedef struct packed {
        logic store;
    } cell_state_t;

endpackage

// File: rtl/pld_edge_sel.sv
module pld_edge_sel #(
    parameter int N_LINES = 4,
    parameter int SEL_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic [SEL_W-1:0]   sel,
    input  logic               neg,
    output logic               edge_hit,
    output logic               level_open
);

    logic [N_LINES-1:0] lines_d, lines_q;
    logic cur_lv, prev_lv;

    always_comb begin
        lines_d = lines;
        cur_lv  = 1'b0;
        prev_lv = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (sel == SEL_W'(i)) begin
                cur_lv  = lines[i];
                prev_lv = lines_q[i];
            end
        end
        edge_hit   = neg ? (prev_lv & ~cur_lv) : (~prev_lv & cur_lv);
        level_open = neg ? ~cur_lv : cur_lv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

endmodule

// File: rtl/pld_sr_sel.sv
module pld_sr_sel #(
    parameter int N_SR  = 3,
    parameter int SEL_W = $clog2(N_SR + 1)
) (
    input  logic [N_SR-1:0]  set_lines,
    input  logic [N_SR-1:0]  rst_lines,
    input  logic [SEL_W-1:0] sel,
    output logic             set_hit,
    output logic             rst_hit
);

    always_comb begin
        set_hit = 1'b0;
        rst_hit = 1'b0;
        for (int i = 0; i < N_SR; i++) begin
            if (sel == SEL_W'(i)) begin
                set_hit = set_lines[i];
                rst_hit = rst_lines[i];
            end
        end
    end

endmodule

// File: rtl/pld_next_fn.sv
module pld_next_fn
    import pld_cell_pkg::*;
(
    input  logic     q,
    input  logic     term_a,
    input  logic     term_b,
    input  logic     pin_in,
    input  ff_kind_e ff,
    input  logic     in_reg,
    input  logic     as_latch,
    input  logic     set_hit,
    input  logic     rst_hit,
    output logic     src,
    output logic     nxt
);

    logic flip;

    always_comb begin
        src  = in_reg ? pin_in : term_a;
        flip = 1'b0;
        if (in_reg || as_latch) begin
            flip = src ^ q;
        end else begin
            unique case (ff)
                FF_D:  flip = term_a ^ q;
                FF_T:  flip = term_a;
                FF_JK: flip = (term_a & ~q) | (term_b & q);
                FF_SR: flip = (term_a & ~term_b & ~q) | (term_b & ~term_a & q);
            endcase
        end
        if (rst_hit)      nxt = 1'b0;
        else if (set_hit) nxt = 1'b1;
        else              nxt = q ^ flip;
    end

endmodule

// File: rtl/pld_cell.sv
module pld_cell
    import pld_cell_pkg::*;
#(
    parameter int N_CLK    = 4,
    parameter int N_SR     = 3,
    parameter int CLK_SEL_W = $clog2(N_CLK),
    parameter int SR_SEL_W  = $clog2(N_SR + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_mode,
    input  logic [1:0]           cfg_ff,
    input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
    input  logic                 cfg_edge_neg,
    input  logic [SR_SEL_W-1:0]  cfg_sr_sel,
    input  logic                 cfg_invert,
    input  logic                 cfg_in_reg,
    input  logic                 term_a,
    input  logic                 term_b,
    input  logic                 pin_in,
    input  logic [N_CLK-1:0]     clk_lines,
    input  logic [N_SR-1:0]      set_lines,
    input  logic [N_SR-1:0]      rst_lines,
    output logic                 cell_out,
    output logic                 fb_out,
    output logic                 pin_oe
);

    cell_state_t st_d, st_q;
    cell_mode_e  mode;
    logic edge_hit, level_open, set_hit, rst_hit, src, nxt, val;

    assign mode = cell_mode_e'(cfg_mode);

    pld_edge_sel #(.N_LINES(N_CLK), .SEL_W(CLK_SEL_W)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines      (clk_lines),
        .sel        (cfg_clk_sel),
        .neg        (cfg_edge_neg),
        .edge_hit   (edge_hit),
        .level_open (level_open)
    );

    pld_sr_sel #(.N_SR(N_SR), .SEL_W(SR_SEL_W)) u_sr (
        .set_lines (set_lines),
        .rst_lines (rst_lines),
        .sel       (cfg_sr_sel),
        .set_hit   (set_hit),
        .rst_hit   (rst_hit)
    );

    pld_next_fn u_next (
        .q        (st_q.store),
        .term_a   (term_a),
        .term_b   (term_b),
        .pin_in   (pin_in),
        .ff       (ff_kind_e'(cfg_ff)),
        .in_reg   (cfg_in_reg),
        .as_latch (mode == MODE_LATCH),
        .set_hit  (set_hit),
        .rst_hit  (rst_hit),
        .src      (src),
        .nxt      (nxt)
    );

    always_comb begin
        st_d = st_q;
        val  = src;
        unique case (mode)
            MODE_REG: begin
                if (edge_hit) st_d.store = nxt;
                val = st_q.store;
            end
            MODE_LATCH: begin
                if (level_open) st_d.store = nxt;
                val = level_open ? nxt : st_q.store;
            end
            MODE_PASS, MODE_PASS2: val = src;
        endcase
        fb_out   = val;
        cell_out = val ^ cfg_invert;
        pin_oe   = ~cfg_in_reg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pld_cell_chk.sv
module pld_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic [1:0] cfg_ff,
    input logic [1:0] cfg_clk_sel,
    input logic       cfg_edge_neg,
    input logic [1:0] cfg_sr_sel,
    input logic       cfg_in_reg,
    input logic       term_a,
    input logic       term_b,
    input logic       pin_in,
    input logic [3:0] clk_lines,
    input logic [2:0] set_lines,
    input logic [2:0] rst_lines,
    input logic       fb_out
);

    logic [3:0] prev_lines;
    logic       cap, sr_rst, sr_any, reg_md;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lines <= '0;
        else        prev_lines <= clk_lines;
    end

    always_comb begin
        reg_md = (cfg_mode == 2'b01);
        cap    = reg_md && (cfg_edge_neg ? (prev_lines[cfg_clk_sel] && !clk_lines[cfg_clk_sel])
                                         : (!prev_lines[cfg_clk_sel] && clk_lines[cfg_clk_sel]));
        sr_rst = (cfg_sr_sel != 2'd3) && rst_lines[cfg_sr_sel];
        sr_any = (cfg_sr_sel != 2'd3) && (rst_lines[cfg_sr_sel] || set_lines[cfg_sr_sel]);
    end

    // R3
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_md && !cap) |=> (cfg_mode != 2'b01 || $stable(fb_out)));

    // R8
    sr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && sr_rst) |=> (cfg_mode != 2'b01 || fb_out == 1'b0));

    // R7
    sr_both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !sr_any && !cfg_in_reg && cfg_ff == 2'b11 && term_a && term_b)
        |=> (cfg_mode != 2'b01 || $stable(fb_out)));

    // R10
    in_reg_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !sr_any && cfg_in_reg) |=> (cfg_mode != 2'b01 || fb_out == $past(pin_in)));

endmodule

bind pld_cell pld_cell_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .cfg_ff       (cfg_ff),
    .cfg_clk_sel  (cfg_clk_sel),
    .cfg_edge_neg (cfg_edge_neg),
    .cfg_sr_sel   (cfg_sr_sel),
    .cfg_in_reg   (cfg_in_reg),
    .term_a       (term_a),
    .term_b       (term_b),
    .pin_in       (pin_in),
    .clk_lines    (clk_lines),
    .set_lines    (set_lines),
    .rst_lines    (rst_lines),
    .fb_out       (fb_out)
);

// File: tb/pld_cell_tb.sv
module pld_cell_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = '0, ff = '0, csel = '0, ssel = 2'd3;
    logic       neg = 1'b0, inv = 1'b0, inreg = 1'b0;
    logic       a = 1'b0, b = 1'b0, pin = 1'b0;
    logic [3:0] lines = '0;
    logic [2:0] setl = '0, rstl = '0;
    logic       cell_out, fb_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic       m_q = 1'b0;
    logic [3:0] m_lq = '0;

    always #10 clk = ~clk;

    pld_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .cfg_ff(ff), .cfg_clk_sel(csel),
        .cfg_edge_neg(neg), .cfg_sr_sel(ssel), .cfg_invert(inv), .cfg_in_reg(inreg),
        .term_a(a), .term_b(b), .pin_in(pin), .clk_lines(lines), .set_lines(setl),
        .rst_lines(rstl), .cell_out(cell_out), .fb_out(fb_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic ref_next(input logic q, input logic s, input logic r, input logic latch);
        logic d;
        if (r) return 1'b0;
        if (s) return 1'b1;
        d = inreg ? pin : a;
        if (inreg || latch) return d;
        case (ff)
            2'b00: return a;
            2'b01: return q ^ a;
            2'b10: return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
            default: return (a && !b) ? 1'b1 : ((b && !a) ? 1'b0 : q);
        endcase
    endfunction

    function automatic string tag_of(input logic hit_sr, input logic hit_cap);
        if (mode == 2'b00 || mode == 2'b11) return "R2";
        if (mode == 2'b10) return "R9";
        if (hit_sr && hit_cap) return "R8";
        if (inreg) return "R10";
        if (neg) return "R4";
        case (ff)
            2'b00: return "R3";
            2'b01: return "R5";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Called after inputs settle, between edges: compare, then advance the model.
    task automatic step_check();
        logic cap, open, s, r, nx, val;
        #1;
        cap  = neg ? (m_lq[csel] & ~lines[csel]) : (~m_lq[csel] & lines[csel]);
        open = neg ? ~lines[csel] : lines[csel];
        s    = (ssel != 2'd3) && setl[ssel];
        r    = (ssel != 2'd3) && rstl[ssel];
        nx   = ref_next(m_q, s, r, mode == 2'b10);
        case (mode)
            2'b01:   val = m_q;
            2'b10:   val = open ? nx : m_q;
            default: val = inreg ? pin : a;
        endcase
        chk(tag_of(s || r, cap || (mode == 2'b10 && open)), fb_out, val);
        chk("R11", cell_out, val ^ inv);
        chk("R10", pin_oe, ~inreg);
        if ((mode == 2'b01 && cap) || (mode == 2'b10 && open)) m_q = nx;
        m_lq = lines;
    endtask

    task automatic drive_step(input logic [3:0] ln, input logic na, input logic nb);
        @(negedge clk);
        lines = ln; a = na; b = nb;
        step_check();
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        // R1: outputs cleared while held in reset
        chk("R1", fb_out, 1'b0);
        chk("R1", cell_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", fb_out, 1'b0);

        // R3: D capture on line 1 rising only; line 0 activity ignored
        mode = 2'b01; ff = 2'b00; csel = 2'd1;
        drive_step(4'b0001, 1'b1, 1'b0);
        drive_step(4'b0000, 1'b1, 1'b0);
        drive_step(4'b0010, 1'b1, 1'b0);
        drive_step(4'b0010, 1'b0, 1'b0);
        chk("R3", fb_out, 1'b1);
        // R6: J=K=1 toggles
        ff = 2'b10;
        drive_step(4'b0000, 1'b1, 1'b1);
        drive_step(4'b0010, 1'b1, 1'b1);
        drive_step(4'b0010, 1'b0, 1'b0);
        chk("R6", fb_out, 1'b0);
        // R7: S=R=1 holds
        ff = 2'b11;
        drive_step(4'b0000, 1'b1, 1'b0);
        drive_step(4'b0010, 1'b1, 1'b0);
        drive_step(4'b0000, 1'b1, 1'b1);
        drive_step(4'b0010, 1'b1, 1'b1);
        drive_step(4'b0010, 1'b0, 1'b0);
        chk("R7", fb_out, 1'b1);
        // R8: reset beats set and data on pair 2; R12: feedback ignores inversion
        ssel = 2'd2; setl = 3'b100; rstl = 3'b100; inv = 1'b1; ff = 2'b00;
        drive_step(4'b0000, 1'b1, 1'b0);
        drive_step(4'b0010, 1'b1, 1'b0);
        drive_step(4'b0010, 1'b1, 1'b0);
        chk("R8", fb_out, 1'b0);
        chk("R12", cell_out, 1'b1);
        setl = '0; rstl = '0; ssel = 2'd3; inv = 1'b0;

        // Constrained random sweep of every mode, type and selection
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (i % 8 == 0) begin
                mode  = 2'($urandom_range(0, 3));
                ff    = 2'($urandom_range(0, 3));
                csel  = 2'($urandom_range(0, 3));
                ssel  = 2'($urandom_range(0, 3));
                neg   = 1'($urandom_range(0, 1));
                inv   = 1'($urandom_range(0, 1));
                inreg = ($urandom_range(0, 4) == 0);
            end
            lines[$urandom_range(0, 3)] ^= 1'b1;
            if ($urandom_range(0, 2) == 0) lines[csel] ^= 1'b1;
            a    = 1'($urandom_range(0, 1));
            b    = 1'($urandom_range(0, 1));
            pin  = 1'($urandom_range(0, 1));
            setl = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
            rstl = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
            step_check();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule